// File: doc/BRIEF.md
# Two-Bus Register-Transfer Datapath

This block is the datapath of a small 32-bit word-addressed processor. All transfers go over two shared buses: a 32-bit data bus and a 32-bit address bus. Each storage element has its own drive enable for the bus or buses it can reach. The elements are the program counter, the instruction register, a sixteen-entry register file, the ALU result latch and an external memory datum. Each bus carries the bitwise OR of the sources enabled onto it. Software must enable at most one source per bus in any cycle.

A sequencer outside the block sets the strobes, one register transfer per cycle. The block has no control logic of its own. It returns the two bus values, the opcode field of the instruction register and a one-bit condition flag to the sequencer. The ALU always takes its right operand from the address bus. Its left operand is the constant one, the data bus, or the low byte of the data bus sign-extended. The condition flag records whether the latched ALU result was non-zero. This allows a branch-on-equal sequence: subtract, capture the flag, then load the PC only when the flag is zero.

Top module: `twobus_datapath`

## Requirements
- R1: After reset the PC, instruction register, ALU result latch, condition flag and all sixteen registers hold zero. A bus with no enabled source reads zero.
- R2: Each bus equals the bitwise OR of its enabled sources. Data-bus sources are the PC, the IR offset, the ALU result latch, the memory datum and read port 1. Address-bus sources are the PC, the ALU result latch, the memory datum and read port 2. At most one source may be enabled per bus in a cycle.
- R3: `ir_load` captures data bus bits 19..0 into the instruction register. `opcode` shows IR bits 19..16. `ir_to_data` places IR bits 7..0 on the data bus with bits 31..8 zero.
- R4: `rf_we` writes the data bus value into one register at the clock edge. With `rf_wr_sel`=0 the register is the one named by IR bits 11..8. With `rf_wr_sel`=1 it is the one named by IR bits 3..0.
- R5: Read port 1 drives the data bus from the register named by IR bits 15..12 when `rf_rd1_sel`=0, or by IR bits 11..8 when `rf_rd1_sel`=1. Read port 2 drives the address bus from the register named by IR bits 15..12.
- R6: The ALU left operand depends on `alu_left_sel`: 0 gives the constant 1, 1 or 3 gives the data bus, and 2 gives data bus bits 7..0 sign-extended. The right operand is the address bus. The operation depends on `alu_op`: 0 passes the left operand, 1 adds, 2 subtracts right from left, and 3 gives the NAND of the two operands.
- R7: `alu_res_load` latches the ALU output. The latch drives the data bus under `alu_res_to_data` and the address bus under `alu_res_to_addr`.
- R8: `cond_load` sets the condition flag to the OR of all 32 ALU output bits in that cycle.
- R9: The PC loads the data bus when `pc_load` is high, or when `pc_load_if_zero` is high and the condition flag is zero. Otherwise the PC holds. The PC drives the data bus under `pc_to_data` and the address bus under `pc_to_addr`.
- R10: Register 0 is an ordinary storage register. A write to it keeps the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 32 | Memory datum available for driving |
| mem_to_data | input | 1 | Memory datum onto data bus |
| mem_to_addr | input | 1 | Memory datum onto address bus |
| pc_load | input | 1 | Unconditional PC load from data bus |
| pc_load_if_zero | input | 1 | PC load from data bus when flag is zero |
| pc_to_data | input | 1 | PC onto data bus |
| pc_to_addr | input | 1 | PC onto address bus |
| ir_load | input | 1 | Instruction register load from data bus |
| ir_to_data | input | 1 | IR offset byte onto data bus |
| rf_rd1_en | input | 1 | Read port 1 onto data bus |
| rf_rd2_en | input | 1 | Read port 2 onto address bus |
| rf_rd1_sel | input | 1 | Read port 1 index field select |
| rf_we | input | 1 | Register write from data bus |
| rf_wr_sel | input | 1 | Write index field select |
| alu_op | input | 2 | ALU operation |
| alu_left_sel | input | 2 | ALU left operand select |
| alu_res_load | input | 1 | Latch ALU output |
| alu_res_to_data | input | 1 | Result latch onto data bus |
| alu_res_to_addr | input | 1 | Result latch onto address bus |
| cond_load | input | 1 | Capture condition flag |
| data_bus | output | 32 | Data bus value |
| addr_bus | output | 32 | Address bus value |
| opcode | output | 4 | IR bits 19..16 |
| cond_bit | output | 1 | Condition flag |

## Verification
The hardest case to reach is an ALU result that combines two independent register values. The right operand can only arrive over the address bus from read port 2. The register index for that port comes from the instruction register, which is itself loaded over the data bus. To set this up, the stimulus first loads an instruction word that names register 5 as write target and stores the right operand there. It then loads a second word that names register 5 as the read-port-2 source. Only then does it drive the left value from the memory datum, for every operation and operand selection. The conditional PC load also needs a preceding ALU cycle to set the flag to one, and then another to clear it to zero.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int WORD_W = 32;
  localparam int IR_W   = 20;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2,
    ALU_NAND = 2'd3
  } alu_op_e;

  typedef enum logic [1:0] {
    LEFT_ONE  = 2'd0,
    LEFT_BUS  = 2'd1,
    LEFT_SEXT = 2'd2,
    LEFT_BUSX = 2'd3
  } left_sel_e;

  function automatic logic [WORD_W-1:0] sext_byte(input logic [WORD_W-1:0] v);
    return {{(WORD_W-8){v[7]}}, v[7:0]};
  endfunction

  function automatic logic [WORD_W-1:0] alu_eval(input alu_op_e op,
                                                 input logic [WORD_W-1:0] l,
                                                 input logic [WORD_W-1:0] r);
    case (op)
      ALU_PASS: return l;
      ALU_ADD:  return l + r;
      ALU_SUB:  return l - r;
      default:  return ~(l & r);
    endcase
  endfunction
endpackage

// File: rtl/dp_bus_or.sv
module dp_bus_or #(
  parameter int N_SRC = 4,
  parameter int W     = 32
) (
  input  logic [N_SRC-1:0][W-1:0] src,
  input  logic [N_SRC-1:0]        en,
  output logic [W-1:0]            bus
);
  logic [N_SRC-1:0][W-1:0] gated;

  for (genvar i = 0; i < N_SRC; i++) begin : g_gate
    assign gated[i] = en[i] ? src[i] : '0;
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < N_SRC; i++) bus = bus | gated[i];
  end
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int W      = 32,
  parameter int N_REGS = 16,
  localparam int AW    = $clog2(N_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr1,
  input  logic [AW-1:0] raddr2,
  output logic [W-1:0]  rdata1,
  output logic [W-1:0]  rdata2
);
  logic [W-1:0] regs [N_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REGS; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata1 = regs[raddr1];
  assign rdata2 = regs[raddr2];

  // R4, R10: a write lands in the addressed entry, entry 0 included
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
(
  input  logic [1:0]        op,
  input  logic [1:0]        left_sel,
  input  logic [WORD_W-1:0] data_bus,
  input  logic [WORD_W-1:0] addr_bus,
  output logic [WORD_W-1:0] left_opnd,
  output logic [WORD_W-1:0] result
);
  always_comb begin
    case (left_sel_e'(left_sel))
      LEFT_ONE:  left_opnd = WORD_W'(1);
      LEFT_SEXT: left_opnd = sext_byte(data_bus);
      default:   left_opnd = data_bus;
    endcase
  end

  assign result = alu_eval(alu_op_e'(op), left_opnd, addr_bus);

  // R6: the sign-extended operand keeps the low byte of the bus
  always_comb begin
    if (left_sel == 2'd2)
      a_r6_sext_low_byte: assert (left_opnd[7:0] == data_bus[7:0]);
  end
endmodule

// File: rtl/twobus_datapath.sv
module twobus_datapath
  import dp_pkg::*;
#(
  parameter int N_REGS = 16,
  localparam int AW    = $clog2(N_REGS),
  localparam int N_DSRC = 5,
  localparam int N_ASRC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_to_data,
  input  logic              mem_to_addr,
  input  logic              pc_load,
  input  logic              pc_load_if_zero,
  input  logic              pc_to_data,
  input  logic              pc_to_addr,
  input  logic              ir_load,
  input  logic              ir_to_data,
  input  logic              rf_rd1_en,
  input  logic              rf_rd2_en,
  input  logic              rf_rd1_sel,
  input  logic              rf_we,
  input  logic              rf_wr_sel,
  input  logic [1:0]        alu_op,
  input  logic [1:0]        alu_left_sel,
  input  logic              alu_res_load,
  input  logic              alu_res_to_data,
  input  logic              alu_res_to_addr,
  input  logic              cond_load,
  output logic [WORD_W-1:0] data_bus,
  output logic [WORD_W-1:0] addr_bus,
  output logic [3:0]        opcode,
  output logic              cond_bit
);
  logic [WORD_W-1:0] pc_q, alu_res_q, alu_out, alu_left, rd1_val, rd2_val;
  logic [IR_W-1:0]   ir_q;
  logic              cond_q;
  logic              pc_we;
  logic [AW-1:0]     fld_a, fld_b, fld_d, rd1_idx, wr_idx;
  logic [WORD_W-1:0] ir_offset;

  // IR fields
  assign fld_a     = ir_q[12 +: AW];
  assign fld_b     = ir_q[8 +: AW];
  assign fld_d     = ir_q[0 +: AW];
  assign rd1_idx   = rf_rd1_sel ? fld_b : fld_a;
  assign wr_idx    = rf_wr_sel  ? fld_d : fld_b;
  assign ir_offset = {{(WORD_W-8){1'b0}}, ir_q[7:0]};
  assign opcode    = ir_q[19:16];

  // bus sources
  logic [N_DSRC-1:0][WORD_W-1:0] dsrc;
  logic [N_DSRC-1:0]             den;
  logic [N_ASRC-1:0][WORD_W-1:0] asrc;
  logic [N_ASRC-1:0]             aen;

  assign dsrc = {pc_q, ir_offset, alu_res_q, mem_rdata, rd1_val};
  assign den  = {pc_to_data, ir_to_data, alu_res_to_data, mem_to_data, rf_rd1_en};
  assign asrc = {pc_q, alu_res_q, mem_rdata, rd2_val};
  assign aen  = {pc_to_addr, alu_res_to_addr, mem_to_addr, rf_rd2_en};

  dp_bus_or #(.N_SRC(N_DSRC), .W(WORD_W)) u_dbus (
    .src(dsrc), .en(den), .bus(data_bus));
  dp_bus_or #(.N_SRC(N_ASRC), .W(WORD_W)) u_abus (
    .src(asrc), .en(aen), .bus(addr_bus));

  dp_regfile #(.W(WORD_W), .N_REGS(N_REGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(wr_idx), .wdata(data_bus),
    .raddr1(rd1_idx), .raddr2(fld_a), .rdata1(rd1_val), .rdata2(rd2_val));

  dp_alu u_alu (
    .op(alu_op), .left_sel(alu_left_sel), .data_bus(data_bus),
    .addr_bus(addr_bus), .left_opnd(alu_left), .result(alu_out));

  assign pc_we = pc_load | (pc_load_if_zero & ~cond_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= '0;
      ir_q      <= '0;
      alu_res_q <= '0;
      cond_q    <= 1'b0;
    end else begin
      if (pc_we)        pc_q      <= data_bus;
      if (ir_load)      ir_q      <= data_bus[IR_W-1:0];
      if (alu_res_load) alu_res_q <= alu_out;
      if (cond_load)    cond_q    <= |alu_out;
    end
  end

  assign cond_bit = cond_q;

  // R2: at most one source per bus
  a_r2_one_data_source: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(den) <= 1);
  a_r2_one_addr_source: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(aen) <= 1);
  // R3: the offset drive leaves the upper bits clear
  a_r3_offset_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (den == 5'b01000) |-> data_bus[WORD_W-1:8] == '0);
  // R8: the flag follows the ALU output it captured
  a_r8_flag_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cond_load |=> cond_bit == ($past(alu_out) != '0));
  // R9: a conditional load with the flag set leaves the PC alone
  a_r9_cond_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_if_zero && !pc_load && cond_bit) |=> $stable(pc_q));
  // R7: a latched result is kept while no new load occurs
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_res_load |=> $stable(alu_res_q));
endmodule

// File: tb/twobus_datapath_tb_top.sv
`timescale 1ns/1ps
module twobus_datapath_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_rdata;
  logic mem_to_data, mem_to_addr, pc_load, pc_load_if_zero, pc_to_data, pc_to_addr;
  logic ir_load, ir_to_data, rf_rd1_en, rf_rd2_en, rf_rd1_sel, rf_we, rf_wr_sel;
  logic [1:0] alu_op, alu_left_sel;
  logic alu_res_load, alu_res_to_data, alu_res_to_addr, cond_load;
  logic [31:0] data_bus, addr_bus;
  logic [3:0]  opcode;
  logic        cond_bit;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 0;
  logic [31:0] shadow [16];

  always #2.5 clk = ~clk;

  twobus_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_to_data(mem_to_data),
    .mem_to_addr(mem_to_addr), .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
    .pc_to_data(pc_to_data), .pc_to_addr(pc_to_addr), .ir_load(ir_load),
    .ir_to_data(ir_to_data), .rf_rd1_en(rf_rd1_en), .rf_rd2_en(rf_rd2_en),
    .rf_rd1_sel(rf_rd1_sel), .rf_we(rf_we), .rf_wr_sel(rf_wr_sel), .alu_op(alu_op),
    .alu_left_sel(alu_left_sel), .alu_res_load(alu_res_load),
    .alu_res_to_data(alu_res_to_data), .alu_res_to_addr(alu_res_to_addr),
    .cond_load(cond_load), .data_bus(data_bus), .addr_bus(addr_bus),
    .opcode(opcode), .cond_bit(cond_bit));

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    mem_rdata = '0; mem_to_data = 0; mem_to_addr = 0; pc_load = 0; pc_load_if_zero = 0;
    pc_to_data = 0; pc_to_addr = 0; ir_load = 0; ir_to_data = 0; rf_rd1_en = 0;
    rf_rd2_en = 0; rf_rd1_sel = 0; rf_we = 0; rf_wr_sel = 0; alu_op = 0;
    alu_left_sel = 0; alu_res_load = 0; alu_res_to_data = 0; alu_res_to_addr = 0;
    cond_load = 0;
  endtask

  // commit the strobes set now at the next edge, return at edge + 1 ns
  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic put_ir(input logic [19:0] w);
    idle(); mem_rdata = {12'h0, w}; mem_to_data = 1; ir_load = 1; step();
  endtask

  task automatic put_reg(input logic sel, input logic [31:0] v);
    idle(); mem_rdata = v; mem_to_data = 1; rf_we = 1; rf_wr_sel = sel; step();
  endtask

  // expected ALU output computed independently
  function automatic logic [31:0] model(input int op, input int ls,
                                        input logic [31:0] a, input logic [31:0] b);
    logic [31:0] l;
    if (ls == 0) l = 32'd1;
    else if (ls == 2) l = 32'(signed'(a[7:0]));
    else l = a;
    case (op)
      0: return l;
      1: return l + b;
      2: return l + (~b) + 32'd1;
      default: return (~l) | (~b);
    endcase
  endfunction

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    report();
    $finish;
  end

  initial begin
    logic [31:0] av [6];
    logic [31:0] bv [4];
    av = '{32'h0, 32'h1, 32'h7F, 32'h80, 32'hFFFF_FFFF, 32'h1234_5678};
    bv = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h0000_00FF};
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1: reset state, idle buses
    #0.5;
    chk("R1 data idle", data_bus, 0);
    chk("R1 addr idle", addr_bus, 0);
    chk("R1 cond", {31'b0, cond_bit}, 0);
    chk("R1 opcode", {28'b0, opcode}, 0);
    pc_to_data = 1; alu_res_to_addr = 1; #0.5;
    chk("R1 pc", data_bus, 0);
    chk("R1 alu latch", addr_bus, 0);
    idle(); ir_to_data = 1; rf_rd2_en = 1; #0.5;
    chk("R1 ir", data_bus, 0);
    chk("R1 reg0", addr_bus, 0);
    idle();
    for (int r = 1; r < 16; r++) begin
      put_ir(20'(r) << 12);
      rf_rd1_en = 1; #0.5;
      chk("R1 reg", data_bus, 0);
      idle();
    end

    // R3: opcode and offset fields for every opcode
    for (int op = 0; op < 16; op++) begin
      logic [19:0] w;
      w = {4'(op), 8'(op * 37 + 5), 8'(op * 29 + 131)};
      put_ir(w);
      ir_to_data = 1; #0.5;
      chk("R3 opcode", {28'b0, opcode}, {28'b0, 4'(op)});
      chk("R3 offset", data_bus, {24'b0, w[7:0]});
      idle();
    end

    // R4, R10: write all registers, alternating write-field selection
    for (int r = 0; r < 16; r++) begin
      shadow[r] = (32'h1357_9BDF * 32'(r + 1)) ^ 32'(r << 20);
      if (r % 2 == 0) begin put_ir(20'(r)); put_reg(1'b1, shadow[r]); end
      else begin put_ir(20'(r) << 8); put_reg(1'b0, shadow[r]); end
    end
    // R5: read both ports with each field selection
    for (int r = 0; r < 16; r++) begin
      put_ir((20'(r) << 12) | (20'(15 - r) << 8));
      rf_rd1_en = 1; rf_rd2_en = 1; rf_rd1_sel = 0; #0.5;
      chk(r == 0 ? "R10 reg0 kept" : "R4 R5 port1 regA", data_bus, shadow[r]);
      chk("R5 port2", addr_bus, shadow[r]);
      rf_rd1_sel = 1; #0.5;
      chk("R5 port1 regB", data_bus, shadow[15 - r]);
      idle();
    end

    // R2: a memory datum on the address bus alone
    mem_rdata = 32'hCAFE_0123; mem_to_addr = 1; #0.5;
    chk("R2 mem addr", addr_bus, 32'hCAFE_0123);
    chk("R2 data untouched", data_bus, 0);
    idle();

    // R6, R7, R8: ALU sweep, right operand via register 5 on read port 2
    foreach (bv[j]) begin
      put_ir(20'h00005);
      put_reg(1'b1, bv[j]);
      put_ir(20'h05000);
      foreach (av[i]) begin
        for (int op = 0; op < 4; op++) begin
          for (int ls = 0; ls < 4; ls++) begin
            logic [31:0] e;
            e = model(op, ls, av[i], bv[j]);
            idle();
            mem_rdata = av[i]; mem_to_data = 1; rf_rd2_en = 1;
            alu_op = 2'(op); alu_left_sel = 2'(ls);
            alu_res_load = 1; cond_load = 1;
            step();
            if ((op + ls) % 2 == 0) begin
              alu_res_to_data = 1; #0.5;
              chk("R6 R7 result data", data_bus, e);
            end else begin
              alu_res_to_addr = 1; #0.5;
              chk("R6 R7 result addr", addr_bus, e);
            end
            chk("R8 flag", {31'b0, cond_bit}, {31'b0, e != 0});
            idle();
          end
        end
      end
    end

    // R7: the latch holds without a load strobe
    mem_rdata = 32'h5; mem_to_data = 1; alu_left_sel = 2'd1; alu_res_load = 1; step();
    mem_rdata = 32'h9; mem_to_data = 1; alu_left_sel = 2'd1; step();
    alu_res_to_data = 1; #0.5;
    chk("R7 hold", data_bus, 32'h5);
    idle();

    // R9: unconditional load, then both bus drives
    mem_rdata = 32'h0000_1234; mem_to_data = 1; pc_load = 1; step();
    pc_to_addr = 1; #0.5;
    chk("R9 pc addr", addr_bus, 32'h0000_1234);
    idle(); pc_to_data = 1; #0.5;
    chk("R9 pc data", data_bus, 32'h0000_1234);
    idle();
    // flag set to one: pass constant 1
    alu_op = 2'd0; alu_left_sel = 2'd0; cond_load = 1; step();
    chk("R8 flag one", {31'b0, cond_bit}, 1);
    mem_rdata = 32'h0000_BEEF; mem_to_data = 1; pc_load_if_zero = 1; step();
    pc_to_addr = 1; #0.5;
    chk("R9 cond blocked", addr_bus, 32'h0000_1234);
    idle();
    // flag cleared: pass zero from data bus
    mem_rdata = 32'h0; mem_to_data = 1; alu_left_sel = 2'd1; cond_load = 1; step();
    chk("R8 flag zero", {31'b0, cond_bit}, 0);
    mem_rdata = 32'h0000_BEEF; mem_to_data = 1; pc_load_if_zero = 1; step();
    pc_to_data = 1; #0.5;
    chk("R9 cond taken", data_bus, 32'h0000_BEEF);
    idle();

    report();
    $finish;
  end
endmodule